// File: doc/BRIEF.md
# Instruction Field Decoder with Immediate Generator

This block is a purely combinational decoder for a 32-bit fixed-length instruction word. The word uses three layouts: a register layout, an immediate layout and a jump layout, and the opcode always sits in the top six bits. The decoder splits the word into its fields and names the operation. It also picks the destination register and decides whether the register file gets written. For immediate-layout instructions it builds the 32-bit operand, which is sign-extended, zero-extended or moved to the upper half, depending on the operation.

A pipeline's decode stage places the block between the fetched word and the register file. Its class flags drive the hazard and control logic, and its operand value feeds the operand multiplexer. The supported subset is register add, register OR, the three shifts, register jump, word load, word store, the two equality branches, OR-immediate, load-upper-immediate and absolute jump. Any other encoding raises the illegal flag.

Top module: `insn_field_decoder`

## Requirements
- R1: Raw fields come straight from the word, whatever the opcode: `opcode_o`=bits 31:26, `rs_o`=25:21, `rt_o`=20:16, `rd_o`=15:11, `func_o`=5:0, `jaddr_o`=25:0.
- R2: Opcodes 000000 (register), 100011 (load), 101011 (store), 000100 and 000101 (branches) and 000010 (jump) set `is_rtype_o`, `is_load_o`, `is_store_o`, `is_branch_o` and `is_jump_o` respectively, with at most one of these set. Register jump sets `is_rtype_o` and `is_jreg_o` but not `is_jump_o`.
- R3: Under opcode 000000, the function codes 100000 (add), 100101 (or), 000000/000010/000011 (left shift, logical right shift, arithmetic right shift) and 001000 (register jump) are legal. Every other function code is illegal.
- R4: `shamt_o` equals bits 10:6 for the three shift function codes and is 0 for all other words.
- R5: The destination `dst_o` is bits 15:11 for add, or and the shifts, and bits 20:16 for load, OR-immediate (001101) and load-upper (001111).
- R6: Store, both branches, jump, register jump and illegal words write nothing: `wr_en_o`=0 and `dst_o`=0.
- R7: A selected destination of register 0 gives `wr_en_o`=0. Any other selected destination gives `wr_en_o`=1.
- R8: For load, store and both branches, `imm_o` is bits 15:0 sign-extended to 32 bits.
- R9: For OR-immediate, `imm_o` is bits 15:0 zero-extended.
- R10: For load-upper, `imm_o` holds bits 15:0 in 31:16 and zeros in 15:0.
- R11: `imm_o` is 0 for register-layout, jump and illegal words.
- R12: An illegal word sets `illegal_o`=1 and clears all class flags. A legal word clears `illegal_o`.
- R13: `kind_o` encodes the operation: add 0, or 1, left shift 2, logical right 3, arithmetic right 4, register jump 5, load 6, store 7, branch-equal 8, branch-not-equal 9, OR-immediate 10, load-upper 11, jump 12, illegal 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| opcode_o | output | 6 | Opcode field |
| rs_o | output | 5 | First source register field |
| rt_o | output | 5 | Second register field |
| rd_o | output | 5 | Register-layout destination field |
| shamt_o | output | 5 | Shift amount, valid for shifts only |
| func_o | output | 6 | Function code field |
| jaddr_o | output | 26 | Jump word-address field |
| kind_o | output | 4 | Operation code (R13) |
| dst_o | output | 5 | Selected destination register |
| wr_en_o | output | 1 | Register write enable |
| imm_o | output | 32 | Extended immediate operand |
| is_rtype_o | output | 1 | Register-layout class |
| is_load_o | output | 1 | Load class |
| is_store_o | output | 1 | Store class |
| is_branch_o | output | 1 | Branch class |
| is_jump_o | output | 1 | Absolute jump class |
| is_jreg_o | output | 1 | Register jump class |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The bench targets immediates with bit 15 set.

- If the sign and zero extension rules were swapped between load and OR-immediate, the top half of the operand would come out wrong.
- Destination register 0 on a writing instruction is tested. If the zero check were missing, register 0 would be written.
- Words that carry non-zero bits 10:6 in a non-shift register instruction are applied. This exposes a stale shift amount, which would corrupt a later shift operand.
- Unknown function codes under the register opcode are applied, together with unlisted opcodes. A design that only decodes opcodes would treat these as legal writers.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int SHAMT_W = 5;
    localparam int FUNC_W  = 6;
    localparam int IMM_W   = 16;
    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int RS_LSB  = OPC_LSB - REG_W;
    localparam int RT_LSB  = RS_LSB - REG_W;
    localparam int RD_LSB  = RT_LSB - REG_W;
    localparam int SH_LSB  = RD_LSB - SHAMT_W;
    localparam int JADDR_W = OPC_LSB;
    localparam int EXT_W   = INSN_W - IMM_W;

    typedef logic [OPC_W-1:0]   opc_t;
    typedef logic [REG_W-1:0]   reg_t;
    typedef logic [SHAMT_W-1:0] shamt_t;
    typedef logic [FUNC_W-1:0]  func_t;
    typedef logic [IMM_W-1:0]   imm16_t;
    typedef logic [JADDR_W-1:0] jaddr_t;
    typedef logic [INSN_W-1:0]  word_t;

    localparam opc_t OPC_REG  = 6'b000000;
    localparam opc_t OPC_J    = 6'b000010;
    localparam opc_t OPC_BEQ  = 6'b000100;
    localparam opc_t OPC_BNE  = 6'b000101;
    localparam opc_t OPC_ORI  = 6'b001101;
    localparam opc_t OPC_LUI  = 6'b001111;
    localparam opc_t OPC_LW   = 6'b100011;
    localparam opc_t OPC_SW   = 6'b101011;

    localparam func_t FN_SLL  = 6'b000000;
    localparam func_t FN_SRL  = 6'b000010;
    localparam func_t FN_SRA  = 6'b000011;
    localparam func_t FN_JR   = 6'b001000;
    localparam func_t FN_ADD  = 6'b100000;
    localparam func_t FN_OR   = 6'b100101;

    typedef enum logic [3:0] {
        K_ADD = 4'd0, K_OR = 4'd1, K_SLL = 4'd2, K_SRL = 4'd3, K_SRA = 4'd4,
        K_JR = 4'd5, K_LW = 4'd6, K_SW = 4'd7, K_BEQ = 4'd8, K_BNE = 4'd9,
        K_ORI = 4'd10, K_LUI = 4'd11, K_J = 4'd12, K_BAD = 4'd15
    } kind_e;

    typedef enum logic [1:0] {
        IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_UPPER
    } imm_mode_e;

    typedef enum logic [1:0] {
        DST_NONE, DST_RD, DST_RT
    } dst_sel_e;

    typedef struct packed {
        opc_t   opc;
        reg_t   rs;
        reg_t   rt;
        reg_t   rd;
        shamt_t shamt;
        func_t  func;
        imm16_t imm;
        jaddr_t jaddr;
    } fields_t;

    typedef struct packed {
        logic rtype;
        logic load;
        logic store;
        logic branch;
        logic jump;
        logic jreg;
        logic illegal;
    } class_t;

    typedef struct packed {
        kind_e     kind;
        class_t    cls;
        imm_mode_e imm_mode;
        dst_sel_e  dst_sel;
        logic      uses_shamt;
    } ctrl_t;

    function automatic logic func_is_shift(func_t f);
        return (f == FN_SLL) || (f == FN_SRL) || (f == FN_SRA);
    endfunction

    function automatic class_t class_none();
        class_t c;
        c = '0;
        return c;
    endfunction
endpackage

// File: rtl/ifd_fields.sv
module ifd_fields
    import ifd_pkg::*;
(
    input  word_t   insn_i,
    output fields_t fields_o
);
    always_comb begin
        fields_o.opc   = insn_i[OPC_LSB +: OPC_W];
        fields_o.rs    = insn_i[RS_LSB  +: REG_W];
        fields_o.rt    = insn_i[RT_LSB  +: REG_W];
        fields_o.rd    = insn_i[RD_LSB  +: REG_W];
        fields_o.shamt = insn_i[SH_LSB  +: SHAMT_W];
        fields_o.func  = insn_i[0 +: FUNC_W];
        fields_o.imm   = insn_i[0 +: IMM_W];
        fields_o.jaddr = insn_i[0 +: JADDR_W];
    end
endmodule

// File: rtl/ifd_classify.sv
module ifd_classify
    import ifd_pkg::*;
(
    input  opc_t  opc_i,
    input  func_t func_i,
    output ctrl_t ctrl_o
);
    always_comb begin
        ctrl_o             = '0;
        ctrl_o.kind        = K_BAD;
        ctrl_o.cls         = class_none();
        ctrl_o.cls.illegal = 1'b1;
        ctrl_o.imm_mode    = IMM_NONE;
        ctrl_o.dst_sel     = DST_NONE;
        ctrl_o.uses_shamt  = 1'b0;
        unique case (opc_i)
            OPC_REG: begin
                ctrl_o.cls.rtype   = 1'b1;
                ctrl_o.cls.illegal = 1'b0;
                ctrl_o.dst_sel     = DST_RD;
                unique case (func_i)
                    FN_ADD: ctrl_o.kind = K_ADD;
                    FN_OR:  ctrl_o.kind = K_OR;
                    FN_SLL: ctrl_o.kind = K_SLL;
                    FN_SRL: ctrl_o.kind = K_SRL;
                    FN_SRA: ctrl_o.kind = K_SRA;
                    FN_JR: begin
                        ctrl_o.kind     = K_JR;
                        ctrl_o.cls.jreg = 1'b1;
                        ctrl_o.dst_sel  = DST_NONE;
                    end
                    default: begin
                        ctrl_o.kind    = K_BAD;
                        ctrl_o.cls     = class_none();
                        ctrl_o.cls.illegal = 1'b1;
                        ctrl_o.dst_sel = DST_NONE;
                    end
                endcase
                ctrl_o.uses_shamt = func_is_shift(func_i);
            end
            OPC_LW: begin
                ctrl_o.kind = K_LW;  ctrl_o.cls.load = 1'b1; ctrl_o.cls.illegal = 1'b0;
                ctrl_o.imm_mode = IMM_SEXT; ctrl_o.dst_sel = DST_RT;
            end
            OPC_SW: begin
                ctrl_o.kind = K_SW;  ctrl_o.cls.store = 1'b1; ctrl_o.cls.illegal = 1'b0;
                ctrl_o.imm_mode = IMM_SEXT;
            end
            OPC_BEQ: begin
                ctrl_o.kind = K_BEQ; ctrl_o.cls.branch = 1'b1; ctrl_o.cls.illegal = 1'b0;
                ctrl_o.imm_mode = IMM_SEXT;
            end
            OPC_BNE: begin
                ctrl_o.kind = K_BNE; ctrl_o.cls.branch = 1'b1; ctrl_o.cls.illegal = 1'b0;
                ctrl_o.imm_mode = IMM_SEXT;
            end
            OPC_ORI: begin
                ctrl_o.kind = K_ORI; ctrl_o.cls.illegal = 1'b0;
                ctrl_o.imm_mode = IMM_ZEXT; ctrl_o.dst_sel = DST_RT;
            end
            OPC_LUI: begin
                ctrl_o.kind = K_LUI; ctrl_o.cls.illegal = 1'b0;
                ctrl_o.imm_mode = IMM_UPPER; ctrl_o.dst_sel = DST_RT;
            end
            OPC_J: begin
                ctrl_o.kind = K_J;   ctrl_o.cls.jump = 1'b1; ctrl_o.cls.illegal = 1'b0;
            end
            default: ;
        endcase
    end

    always_comb begin
        assert_class_exclusive_R2: assert ($onehot0({ctrl_o.cls.rtype, ctrl_o.cls.load,
            ctrl_o.cls.store, ctrl_o.cls.branch, ctrl_o.cls.jump}))
            else $error("class flags not exclusive");
        if (ctrl_o.cls.illegal)
            assert_illegal_quiet_R12: assert (ctrl_o.dst_sel == DST_NONE
                && ctrl_o.imm_mode == IMM_NONE && !ctrl_o.cls.rtype && !ctrl_o.cls.jreg)
                else $error("illegal word still drives control");
    end
endmodule

// File: rtl/ifd_immgen.sv
module ifd_immgen
    import ifd_pkg::*;
(
    input  imm16_t    imm_i,
    input  imm_mode_e mode_i,
    output word_t     imm_o
);
    always_comb begin
        unique case (mode_i)
            IMM_SEXT:  imm_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
            IMM_ZEXT:  imm_o = {{EXT_W{1'b0}}, imm_i};
            IMM_UPPER: imm_o = {imm_i, {EXT_W{1'b0}}};
            default:   imm_o = '0;
        endcase
    end

    always_comb begin
        if (mode_i == IMM_UPPER)
            assert_upper_low_clear_R10: assert (imm_o[IMM_W-1:0] == '0)
                else $error("upper immediate low half not clear");
        if (mode_i == IMM_ZEXT)
            assert_zext_high_clear_R9: assert (imm_o[INSN_W-1:IMM_W] == '0)
                else $error("zero extension leaked sign");
        if (mode_i == IMM_SEXT)
            assert_sext_copies_sign_R8: assert (imm_o[INSN_W-1:IMM_W] == '0
                || imm_o[INSN_W-1:IMM_W] == '1)
                else $error("sign extension not uniform");
    end
endmodule

// File: rtl/ifd_dest.sv
module ifd_dest
    import ifd_pkg::*;
(
    input  dst_sel_e sel_i,
    input  reg_t     rd_i,
    input  reg_t     rt_i,
    output reg_t     dst_o,
    output logic     wr_en_o
);
    always_comb begin
        unique case (sel_i)
            DST_RD:  dst_o = rd_i;
            DST_RT:  dst_o = rt_i;
            default: dst_o = '0;
        endcase
        wr_en_o = (sel_i != DST_NONE) && (dst_o != '0);
    end

    always_comb begin
        if (wr_en_o)
            assert_no_zero_write_R7: assert (dst_o != '0)
                else $error("write enabled toward register zero");
        if (sel_i == DST_NONE)
            assert_none_no_write_R6: assert (!wr_en_o && dst_o == '0)
                else $error("non-writing class asserts write");
    end
endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
    import ifd_pkg::*;
(
    input  logic [31:0] insn_i,
    output logic [5:0]  opcode_o,
    output logic [4:0]  rs_o,
    output logic [4:0]  rt_o,
    output logic [4:0]  rd_o,
    output logic [4:0]  shamt_o,
    output logic [5:0]  func_o,
    output logic [25:0] jaddr_o,
    output logic [3:0]  kind_o,
    output logic [4:0]  dst_o,
    output logic        wr_en_o,
    output logic [31:0] imm_o,
    output logic        is_rtype_o,
    output logic        is_load_o,
    output logic        is_store_o,
    output logic        is_branch_o,
    output logic        is_jump_o,
    output logic        is_jreg_o,
    output logic        illegal_o
);
    fields_t f;
    ctrl_t   c;

    ifd_fields u_fields (.insn_i(insn_i), .fields_o(f));

    ifd_classify u_class (.opc_i(f.opc), .func_i(f.func), .ctrl_o(c));

    ifd_immgen u_imm (.imm_i(f.imm), .mode_i(c.imm_mode), .imm_o(imm_o));

    ifd_dest u_dest (.sel_i(c.dst_sel), .rd_i(f.rd), .rt_i(f.rt),
                     .dst_o(dst_o), .wr_en_o(wr_en_o));

    assign opcode_o    = f.opc;
    assign rs_o        = f.rs;
    assign rt_o        = f.rt;
    assign rd_o        = f.rd;
    assign func_o      = f.func;
    assign jaddr_o     = f.jaddr;
    assign shamt_o     = c.uses_shamt ? f.shamt : '0;
    assign kind_o      = c.kind;
    assign is_rtype_o  = c.cls.rtype;
    assign is_load_o   = c.cls.load;
    assign is_store_o  = c.cls.store;
    assign is_branch_o = c.cls.branch;
    assign is_jump_o   = c.cls.jump;
    assign is_jreg_o   = c.cls.jreg;
    assign illegal_o   = c.cls.illegal;

    always_comb begin
        if (!c.uses_shamt)
            assert_shamt_masked_R4: assert (shamt_o == '0)
                else $error("shift amount leaks on non-shift");
        if (is_store_o || is_branch_o || is_jump_o || is_jreg_o || illegal_o)
            assert_nonwriter_idle_R6: assert (!wr_en_o)
                else $error("non-writer enables write");
        if (is_jump_o || is_rtype_o || illegal_o)
            assert_no_imm_R11: assert (imm_o == '0)
                else $error("immediate driven for non-immediate class");
    end
endmodule

// File: tb/insn_field_decoder_tb_top.sv
module insn_field_decoder_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [31:0] insn;
    logic [5:0]  opcode, func;
    logic [4:0]  rs, rt, rd, shamt, dst;
    logic [25:0] jaddr;
    logic [3:0]  kind;
    logic [31:0] imm;
    logic wr_en, is_r, is_ld, is_st, is_br, is_j, is_jr, ill;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    insn_field_decoder dut_i (
        .insn_i(insn), .opcode_o(opcode), .rs_o(rs), .rt_o(rt), .rd_o(rd),
        .shamt_o(shamt), .func_o(func), .jaddr_o(jaddr), .kind_o(kind),
        .dst_o(dst), .wr_en_o(wr_en), .imm_o(imm), .is_rtype_o(is_r),
        .is_load_o(is_ld), .is_store_o(is_st), .is_branch_o(is_br),
        .is_jump_o(is_j), .is_jreg_o(is_jr), .illegal_o(ill));

    typedef struct {
        logic [3:0]  kind;
        logic [4:0]  shamt, dst;
        logic        wr;
        logic [31:0] imm;
        logic [6:0]  flags; // rtype load store branch jump jreg illegal
    } exp_t;

    function automatic exp_t model(logic [31:0] w);
        exp_t e;
        logic [15:0] k = w[15:0];
        e.kind = 4'd15; e.shamt = 0; e.dst = 0; e.wr = 0; e.imm = 0;
        e.flags = 7'b0000001;
        case (w[31:26])
            6'b000000: begin
                e.flags = 7'b1000000;
                case (w[5:0])
                    6'b100000: begin e.kind = 0; e.dst = w[15:11]; end
                    6'b100101: begin e.kind = 1; e.dst = w[15:11]; end
                    6'b000000: begin e.kind = 2; e.dst = w[15:11]; e.shamt = w[10:6]; end
                    6'b000010: begin e.kind = 3; e.dst = w[15:11]; e.shamt = w[10:6]; end
                    6'b000011: begin e.kind = 4; e.dst = w[15:11]; e.shamt = w[10:6]; end
                    6'b001000: begin e.kind = 5; e.flags = 7'b1000010; end
                    default:   begin e.kind = 15; e.flags = 7'b0000001; end
                endcase
            end
            6'b100011: begin e.kind = 6;  e.flags = 7'b0100000; e.dst = w[20:16]; e.imm = {{16{k[15]}}, k}; end
            6'b101011: begin e.kind = 7;  e.flags = 7'b0010000; e.imm = {{16{k[15]}}, k}; end
            6'b000100: begin e.kind = 8;  e.flags = 7'b0001000; e.imm = {{16{k[15]}}, k}; end
            6'b000101: begin e.kind = 9;  e.flags = 7'b0001000; e.imm = {{16{k[15]}}, k}; end
            6'b001101: begin e.kind = 10; e.flags = 7'b0000000; e.dst = w[20:16]; e.imm = {16'h0, k}; end
            6'b001111: begin e.kind = 11; e.flags = 7'b0000000; e.dst = w[20:16]; e.imm = {k, 16'h0}; end
            6'b000010: begin e.kind = 12; e.flags = 7'b0000100; end
            default: ;
        endcase
        e.wr = (e.dst != 0);
        return e;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s insn=%08h actual=%0h expected=%0h", req, insn, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] w);
        exp_t e;
        @(negedge clk);
        insn = w;
        #1;
        e = model(w);
        chk("R1 opcode", {26'd0, opcode}, {26'd0, w[31:26]});
        chk("R1 rs/rt/rd", {17'd0, rs, rt, rd}, {17'd0, w[25:11]});
        chk("R1 func/jaddr", {jaddr, func}, {w[25:0], w[5:0]});
        chk("R2 R3 R12 flags", {25'd0, is_r, is_ld, is_st, is_br, is_j, is_jr, ill}, {25'd0, e.flags});
        chk("R4 shamt", {27'd0, shamt}, {27'd0, e.shamt});
        chk("R5 R6 dst", {27'd0, dst}, {27'd0, e.dst});
        chk("R6 R7 wr_en", {31'd0, wr_en}, {31'd0, e.wr});
        chk("R8 R9 R10 R11 imm", imm, e.imm);
        chk("R13 kind", {28'd0, kind}, {28'd0, e.kind});
    endtask

    localparam logic [5:0] OPS [9] = '{6'h00, 6'h23, 6'h2b, 6'h04, 6'h05, 6'h0d, 6'h0f, 6'h02, 6'h00};
    localparam logic [5:0] FNS [6] = '{6'h20, 6'h25, 6'h00, 6'h02, 6'h03, 6'h08};

    initial begin
        insn = '0;
        void'($urandom(32'd2024));
        // reset-like idle word: left shift into register 0, no write (R7)
        apply(32'h0000_0000);
        // R7: load targeting register 0
        apply({6'h23, 5'd3, 5'd0, 16'h0010});
        // R8: load with negative offset
        apply({6'h23, 5'd1, 5'd9, 16'h8000});
        // R9: OR-immediate with bit 15 set stays zero-extended
        apply({6'h0d, 5'd4, 5'd4, 16'h8000});
        // R10: load-upper
        apply({6'h0f, 5'd0, 5'd16, 16'hFFFF});
        // R8: branch forward by 3
        apply({6'h04, 5'd1, 5'd0, 16'h0003});
        // R6: store with rt nonzero
        apply({6'h2b, 5'd29, 5'd8, 16'hFFFC});
        // R4: add with junk in shift field
        apply({6'h00, 5'd1, 5'd2, 5'd3, 5'd31, 6'h20});
        // R4: arithmetic right shift with amount
        apply({6'h00, 5'd0, 5'd2, 5'd3, 5'd17, 6'h03});
        // R3 R12: unknown function code
        apply({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h3f});
        // R12: unlisted opcode
        apply(32'hFFFF_FFFF);
        // R2: register jump, jump
        apply({6'h00, 5'd31, 15'd0, 6'h08});
        apply({6'h02, 26'h3FF_FFFF});
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w = $urandom;
            if ((i % 8) != 0) w[31:26] = OPS[$urandom_range(0, 8)];
            if (w[31:26] == 6'h00 && (i % 5) != 0) w[5:0] = FNS[$urandom_range(0, 5)];
            apply(w);
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule